// File: doc/BRIEF.md
# Fused Multiply-Add Special-Operand Resolver

This combinational block sits at the front of a single-precision fused multiply-add unit. The unit computes z + x*y, or z - x*y when the negate control is set. The block receives the three 32-bit operands together with a class code for each one, which an upstream classifier supplies. It then decides whether the result is already fixed by the operand classes alone: NaN propagation, infinities, invalid products, zero products, and a special addend that overrides a finite product.

When the result is settled, the block raises `bypass_valid`, drives the final word on `result` and reports `invalid_op`. When arithmetic is still needed, it raises `proceed` instead. It also raises one normalize request for each operand that is denormal, so the significand datapath downstream knows which inputs to pre-normalize.

Top module: `fma_special_resolver`

## Requirements
- R1: Class codes are 3'd0 signaling NaN, 3'd1 quiet NaN, 3'd2 zero, 3'd3 normal, 3'd4 denormal and 3'd5 infinity. A signaling NaN in z beats every other case: `invalid_op` is 1 and the result is z quieted. Quieting sets bit 22 and keeps the sign, the exponent and every other fraction bit.
- R2: If z is not a signaling NaN and x is a signaling NaN, the result is x quieted, even when y is also signaling. Otherwise, if y is a signaling NaN, the result is y quieted. Both cases raise `invalid_op`.
- R3: If no operand is signaling and x or y is a quiet NaN, that multiplicand is returned unchanged, with x preferred over y and `invalid_op` 0.
- R4: Infinity times zero, in either order, returns z unchanged if z is a quiet NaN. Otherwise it raises `invalid_op` and returns the DEFAULT_NAN pattern (32'h7FC00000 by default).
- R5: Infinity times a nonzero non-NaN value returns z if z is a quiet NaN. Otherwise it returns an infinity (exponent all ones, fraction 0) carrying the product sign, which is x sign XOR y sign.
- R6: An infinite product meeting an infinite z of the opposite sign raises `invalid_op` and returns DEFAULT_NAN.
- R7: When one multiplicand is zero and the other is zero, normal or denormal, the result is an infinity with z's sign if z is infinite, and z unchanged otherwise. `invalid_op` is 0.
- R8: When both multiplicands are normal or denormal, a quiet-NaN z is returned unchanged and an infinite z gives an infinity with z's sign. Any other z sets `proceed` with `result` 0 and `invalid_op` 0.
- R9: Each normalize request is 1 only while `proceed` is 1 and its own operand's class is denormal.
- R10: When `negate_product` is 1, the product sign is inverted before every sign-dependent decision (R5, R6).
- R11: For every input, exactly one of `bypass_valid` and `proceed` is 1, and a bypassed result is never a signaling NaN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_x | input | 32 | First multiplicand |
| op_y | input | 32 | Second multiplicand |
| op_z | input | 32 | Addend |
| cls_x | input | 3 | Class code of op_x |
| cls_y | input | 3 | Class code of op_y |
| cls_z | input | 3 | Class code of op_z |
| negate_product | input | 1 | Invert the product sign (multiply-subtract) |
| bypass_valid | output | 1 | Result settled without arithmetic |
| result | output | 32 | Settled result, 0 when proceeding |
| invalid_op | output | 1 | Invalid-operation exception |
| proceed | output | 1 | Arithmetic datapath must compute the result |
| norm_x | output | 1 | Normalize request for op_x |
| norm_y | output | 1 | Normalize request for op_y |
| norm_z | output | 1 | Normalize request for op_z |

## Verification
The embedded assertions check, for every input combination, a set of structural rules:
- exactly one of bypass and proceed is raised;
- a bypassed word is never a signaling NaN;
- normalize requests appear only with proceed;
- proceeding leaves the result and the invalid flag clear;
- a signaling addend always raises invalid with the quiet bit set;
- an invalid product yields the default NaN.

The priority chain itself can only be shown by the bench's scenarios. This covers which NaN wins among the three operands, the quiet-NaN addend overriding an infinite or invalid product, the sign chosen for each infinity, and the effect of the negate control on opposite-sign infinities.

// File: rtl/fma_sc_pkg.sv
package fma_sc_pkg;

    parameter int EXP_W  = 8;
    parameter int FRAC_W = 23;
    localparam int WORD_W  = 1 + EXP_W + FRAC_W;
    localparam int CLS_W   = 3;
    localparam int QBIT    = FRAC_W - 1;
    localparam int N_OPS   = 3;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [CLS_W-1:0] {
        CL_SNAN  = 3'd0,
        CL_QNAN  = 3'd1,
        CL_ZERO  = 3'd2,
        CL_NORM  = 3'd3,
        CL_DNORM = 3'd4,
        CL_INF   = 3'd5
    } op_class_e;

    typedef struct packed {
        logic  hit;
        logic  invalid;
        word_t value;
    } verdict_t;

    function automatic word_t quieten(input word_t w);
        word_t q;
        q = w;
        q[QBIT] = 1'b1;
        return q;
    endfunction

    function automatic word_t make_inf(input logic sgn);
        return {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    endfunction

    function automatic logic sign_of(input word_t w);
        return w[WORD_W-1];
    endfunction

    function automatic logic is_finite_nz(input op_class_e c);
        return (c == CL_NORM) || (c == CL_DNORM);
    endfunction

    function automatic logic is_snan_word(input word_t w);
        return (&w[WORD_W-2:FRAC_W]) && !w[QBIT] && (|w[QBIT-1:0]);
    endfunction

endpackage

// File: rtl/fma_sc_nan_stage.sv
module fma_sc_nan_stage
    import fma_sc_pkg::*;
(
    input  word_t     x,
    input  word_t     y,
    input  word_t     z,
    input  op_class_e xc,
    input  op_class_e yc,
    input  op_class_e zc,
    output verdict_t  verdict
);

    always_comb begin
        verdict = '0;
        if (zc == CL_SNAN) begin
            verdict.hit     = 1'b1;
            verdict.invalid = 1'b1;
            verdict.value   = quieten(z);
        end else if (xc == CL_SNAN) begin
            verdict.hit     = 1'b1;
            verdict.invalid = 1'b1;
            verdict.value   = quieten(x);
        end else if (yc == CL_SNAN) begin
            verdict.hit     = 1'b1;
            verdict.invalid = 1'b1;
            verdict.value   = quieten(y);
        end else if (xc == CL_QNAN) begin
            verdict.hit     = 1'b1;
            verdict.value   = x;
        end else if (yc == CL_QNAN) begin
            verdict.hit     = 1'b1;
            verdict.value   = y;
        end
    end

    always_comb begin
        if (zc == CL_SNAN)
            AST_ZSNAN_INVALID: assert (verdict.hit && verdict.invalid && verdict.value[QBIT]); // R1
        if (zc != CL_SNAN && xc == CL_SNAN)
            AST_XSNAN_WINS: assert (verdict.value[WORD_W-1] == x[WORD_W-1] && verdict.invalid); // R2
    end

endmodule

// File: rtl/fma_sc_prod_stage.sv
module fma_sc_prod_stage
    import fma_sc_pkg::*;
#(
    parameter word_t DEFAULT_NAN = 32'h7FC0_0000
)(
    input  word_t     z,
    input  op_class_e xc,
    input  op_class_e yc,
    input  op_class_e zc,
    input  logic      prod_sign,
    output verdict_t  verdict,
    output logic      go
);

    logic x_inf, y_inf, x_zero, y_zero;
    logic z_qnan, z_inf, z_sign;
    logic inf_times_zero, inf_product, zero_product;

    always_comb begin
        x_inf  = (xc == CL_INF);
        y_inf  = (yc == CL_INF);
        x_zero = (xc == CL_ZERO);
        y_zero = (yc == CL_ZERO);
        z_qnan = (zc == CL_QNAN);
        z_inf  = (zc == CL_INF);
        z_sign = sign_of(z);
        inf_times_zero = (x_inf && y_zero) || (x_zero && y_inf);
        inf_product    = (x_inf || y_inf) && !inf_times_zero;
        zero_product   = (x_zero || y_zero) && !inf_times_zero;
    end

    always_comb begin
        verdict = '0;
        go      = 1'b0;
        if (inf_times_zero) begin
            verdict.hit = 1'b1;
            if (z_qnan) begin
                verdict.value = z;
            end else begin
                verdict.invalid = 1'b1;
                verdict.value   = DEFAULT_NAN;
            end
        end else if (inf_product) begin
            verdict.hit = 1'b1;
            if (z_qnan) begin
                verdict.value = z;
            end else if (z_inf && (z_sign != prod_sign)) begin
                verdict.invalid = 1'b1;
                verdict.value   = DEFAULT_NAN;
            end else begin
                verdict.value = make_inf(prod_sign);
            end
        end else if (zero_product) begin
            verdict.hit   = 1'b1;
            verdict.value = z_inf ? make_inf(z_sign) : z;
        end else if (z_qnan) begin
            verdict.hit   = 1'b1;
            verdict.value = z;
        end else if (z_inf) begin
            verdict.hit   = 1'b1;
            verdict.value = make_inf(z_sign);
        end else begin
            go = is_finite_nz(xc) && is_finite_nz(yc);
        end
    end

    always_comb begin
        if (verdict.invalid)
            AST_INVALID_DEFAULT: assert (verdict.value == DEFAULT_NAN); // R4
        if (go)
            AST_GO_NO_HIT: assert (!verdict.hit); // R8
    end

endmodule

// File: rtl/fma_sc_norm_req.sv
module fma_sc_norm_req
    import fma_sc_pkg::*;
(
    input  logic                  go,
    input  logic [N_OPS*CLS_W-1:0] classes,
    output logic [N_OPS-1:0]       req
);

    for (genvar i = 0; i < N_OPS; i++) begin : g_op
        op_class_e c;
        assign c      = op_class_e'(classes[i*CLS_W +: CLS_W]);
        assign req[i] = go && (c == CL_DNORM);
    end

endmodule

// File: rtl/fma_special_resolver.sv
module fma_special_resolver
    import fma_sc_pkg::*;
#(
    parameter logic [31:0] DEFAULT_NAN = 32'h7FC0_0000
)(
    input  logic [31:0] op_x,
    input  logic [31:0] op_y,
    input  logic [31:0] op_z,
    input  logic [2:0]  cls_x,
    input  logic [2:0]  cls_y,
    input  logic [2:0]  cls_z,
    input  logic        negate_product,
    output logic        bypass_valid,
    output logic [31:0] result,
    output logic        invalid_op,
    output logic        proceed,
    output logic        norm_x,
    output logic        norm_y,
    output logic        norm_z
);

    op_class_e  xc, yc, zc;
    logic       prod_sign;
    verdict_t   nan_v, prod_v;
    logic       prod_go;
    logic [N_OPS-1:0] nreq;

    assign xc = op_class_e'(cls_x);
    assign yc = op_class_e'(cls_y);
    assign zc = op_class_e'(cls_z);
    assign prod_sign = sign_of(op_x) ^ sign_of(op_y) ^ negate_product;

    fma_sc_nan_stage u_nan (
        .x       (op_x),
        .y       (op_y),
        .z       (op_z),
        .xc      (xc),
        .yc      (yc),
        .zc      (zc),
        .verdict (nan_v)
    );

    fma_sc_prod_stage #(
        .DEFAULT_NAN (DEFAULT_NAN)
    ) u_prod (
        .z         (op_z),
        .xc        (xc),
        .yc        (yc),
        .zc        (zc),
        .prod_sign (prod_sign),
        .verdict   (prod_v),
        .go        (prod_go)
    );

    fma_sc_norm_req u_norm (
        .go      (proceed),
        .classes ({cls_z, cls_y, cls_x}),
        .req     (nreq)
    );

    always_comb begin
        bypass_valid = 1'b0;
        result       = '0;
        invalid_op   = 1'b0;
        proceed      = 1'b0;
        if (nan_v.hit) begin
            bypass_valid = 1'b1;
            result       = nan_v.value;
            invalid_op   = nan_v.invalid;
        end else if (prod_v.hit) begin
            bypass_valid = 1'b1;
            result       = prod_v.value;
            invalid_op   = prod_v.invalid;
        end else begin
            proceed = prod_go;
        end
    end

    assign norm_x = nreq[0];
    assign norm_y = nreq[1];
    assign norm_z = nreq[2];

    always_comb begin
        if (xc <= CL_INF && yc <= CL_INF && zc <= CL_INF)
            AST_PATH_ONEHOT: assert ($onehot({bypass_valid, proceed})); // R11
        if (bypass_valid)
            AST_NO_SNAN_OUT: assert (!is_snan_word(result)); // R11
        if (norm_x || norm_y || norm_z)
            AST_NORM_NEEDS_PROCEED: assert (proceed); // R9
        if (proceed)
            AST_PROCEED_CLEAN: assert (result == '0 && !invalid_op); // R8
    end

endmodule

// File: tb/tb_fma_special_resolver.sv
module tb_fma_special_resolver;

    localparam int CLK_PERIOD = 10;
    localparam int N_RANDOM   = 4000;
    localparam logic [31:0] DNAN = 32'h7FC0_0000;

    localparam logic [2:0] C_SN = 3'd0, C_QN = 3'd1, C_ZE = 3'd2,
                           C_NO = 3'd3, C_DN = 3'd4, C_IN = 3'd5;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [31:0] op_x, op_y, op_z;
    logic [2:0]  cls_x, cls_y, cls_z;
    logic        negate_product;
    logic        bypass_valid, invalid_op, proceed, norm_x, norm_y, norm_z;
    logic [31:0] result;

    int checks = 0;
    int fails  = 0;

    fma_special_resolver dut (
        .op_x (op_x), .op_y (op_y), .op_z (op_z),
        .cls_x (cls_x), .cls_y (cls_y), .cls_z (cls_z),
        .negate_product (negate_product),
        .bypass_valid (bypass_valid), .result (result),
        .invalid_op (invalid_op), .proceed (proceed),
        .norm_x (norm_x), .norm_y (norm_y), .norm_z (norm_z)
    );

    typedef struct packed {
        logic        byp;
        logic [31:0] res;
        logic        inv;
        logic        go;
        logic [2:0]  nrm;
    } exp_t;

    function automatic logic [31:0] inf_w(input logic s);
        return {s, 8'hFF, 23'd0};
    endfunction

    function automatic logic [31:0] q(input logic [31:0] w);
        return w | 32'h0040_0000;
    endfunction

    function automatic exp_t model(input logic [2:0] xc, input logic [2:0] yc, input logic [2:0] zc,
                                   input logic [31:0] x, input logic [31:0] y, input logic [31:0] z,
                                   input logic ng, output string tag);
        exp_t e;
        logic ps, xinf, yinf, xz, yz;
        e = '0;
        e.byp = 1'b1;
        ps = x[31] ^ y[31] ^ ng;
        xinf = (xc == C_IN); yinf = (yc == C_IN);
        xz = (xc == C_ZE);   yz = (yc == C_ZE);
        if (zc == C_SN) begin tag = "R1"; e.inv = 1; e.res = q(z); end
        else if (xc == C_SN) begin tag = "R2"; e.inv = 1; e.res = q(x); end
        else if (yc == C_SN) begin tag = "R2"; e.inv = 1; e.res = q(y); end
        else if (xc == C_QN) begin tag = "R3"; e.res = x; end
        else if (yc == C_QN) begin tag = "R3"; e.res = y; end
        else if ((xinf && yz) || (xz && yinf)) begin
            tag = "R4";
            if (zc == C_QN) e.res = z; else begin e.inv = 1; e.res = DNAN; end
        end else if (xinf || yinf) begin
            tag = ng ? "R10" : "R5";
            if (zc == C_QN) e.res = z;
            else if (zc == C_IN && z[31] != ps) begin tag = "R6"; e.inv = 1; e.res = DNAN; end
            else e.res = inf_w(ps);
        end else if (xz || yz) begin
            tag = "R7";
            e.res = (zc == C_IN) ? inf_w(z[31]) : z;
        end else begin
            tag = "R8";
            if (zc == C_QN) e.res = z;
            else if (zc == C_IN) e.res = inf_w(z[31]);
            else begin
                e.byp = 0; e.go = 1;
                e.nrm = {zc == C_DN, yc == C_DN, xc == C_DN};
                if (e.nrm != 3'b000) tag = "R9";
            end
        end
        return e;
    endfunction

    function automatic logic [31:0] mk(input logic [2:0] c);
        logic [31:0] r;
        logic [7:0]  ex;
        r = $urandom;
        case (c)
            C_SN: return {r[31], 8'hFF, 1'b0, r[21:0] | 22'h1};
            C_QN: return {r[31], 8'hFF, 1'b1, r[21:0]};
            C_ZE: return {r[31], 31'd0};
            C_DN: return {r[31], 8'h00, r[22:0] | 23'h1};
            C_IN: return inf_w(r[31]);
            default: begin
                ex = r[30:23];
                if (ex == 8'h00 || ex == 8'hFF) ex = 8'h7F;
                return {r[31], ex, r[22:0]};
            end
        endcase
    endfunction

    task automatic apply(input logic [2:0] xc, input logic [2:0] yc, input logic [2:0] zc,
                         input logic [31:0] x, input logic [31:0] y, input logic [31:0] z,
                         input logic ng);
        exp_t e, a;
        string tag;
        @(negedge clk);
        op_x = x; op_y = y; op_z = z;
        cls_x = xc; cls_y = yc; cls_z = zc;
        negate_product = ng;
        #1;
        e = model(xc, yc, zc, x, y, z, ng, tag);
        a = {bypass_valid, result, invalid_op, proceed, norm_z, norm_y, norm_x};
        checks++;
        if (a != e) begin
            fails++;
            $display("FAIL %s cls=%0d/%0d/%0d ng=%0b actual byp=%0b res=%h inv=%0b go=%0b nrm=%b expected byp=%0b res=%h inv=%0b go=%0b nrm=%b",
                     tag, xc, yc, zc, ng, a.byp, a.res, a.inv, a.go, a.nrm,
                     e.byp, e.res, e.inv, e.go, e.nrm);
        end
    endtask

    task automatic dir(input logic [2:0] xc, input logic [2:0] yc, input logic [2:0] zc,
                       input logic [31:0] x, input logic [31:0] y, input logic [31:0] z,
                       input logic ng);
        apply(xc, yc, zc, x, y, z, ng);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        op_x = '0; op_y = '0; op_z = '0;
        cls_x = C_ZE; cls_y = C_ZE; cls_z = C_ZE;
        negate_product = 1'b0;

        // R7: all-zero idle inputs return z
        dir(C_ZE, C_ZE, C_ZE, 32'h0, 32'h0, 32'h0, 0);
        // R1: z signaling beats x signaling
        dir(C_SN, C_NO, C_SN, 32'h7F80_0001, 32'h3F80_0000, 32'hFF81_2345, 0);
        // R2: x signaling beats y signaling
        dir(C_SN, C_SN, C_NO, 32'hFF80_00AA, 32'h7F80_0055, 32'h3F80_0000, 0);
        // R2: y signaling alone
        dir(C_NO, C_SN, C_QN, 32'h3F80_0000, 32'h7F80_0055, 32'h7FC0_0001, 0);
        // R3: both quiet, x wins
        dir(C_QN, C_QN, C_NO, 32'h7FC0_1111, 32'hFFC0_2222, 32'h3F80_0000, 0);
        // R4: inf*zero with quiet z, and with normal z
        dir(C_IN, C_ZE, C_QN, 32'h7F80_0000, 32'h0, 32'h7FC0_0777, 0);
        dir(C_ZE, C_IN, C_NO, 32'h8000_0000, 32'hFF80_0000, 32'h3F80_0000, 0);
        // R5: inf*norm, z normal
        dir(C_IN, C_NO, C_NO, 32'h7F80_0000, 32'hBF80_0000, 32'h3F80_0000, 0);
        // R6: +inf product, -inf z
        dir(C_IN, C_NO, C_IN, 32'h7F80_0000, 32'h3F80_0000, 32'hFF80_0000, 0);
        // R10: negate makes same-sign infinities opposite
        dir(C_IN, C_NO, C_IN, 32'h7F80_0000, 32'h3F80_0000, 32'h7F80_0000, 1);
        // R10: negate flips infinite product sign
        dir(C_IN, C_DN, C_ZE, 32'h7F80_0000, 32'h0000_0001, 32'h0, 1);
        // R7: zero product with infinite z
        dir(C_ZE, C_NO, C_IN, 32'h0, 32'h4000_0000, 32'hFF80_0000, 0);
        // R8: finite product with infinite z, and proceed
        dir(C_NO, C_NO, C_IN, 32'h3F80_0000, 32'h4000_0000, 32'hFF80_0000, 0);
        dir(C_NO, C_NO, C_NO, 32'h3F80_0000, 32'h4000_0000, 32'h4040_0000, 0);
        // R9: denormal multiplicand and addend requests
        dir(C_DN, C_NO, C_DN, 32'h0000_0010, 32'h4000_0000, 32'h8000_0003, 0);
        dir(C_NO, C_DN, C_NO, 32'h3F80_0000, 32'h0000_0100, 32'h3F80_0000, 0);

        // R11 and all others: random mix of classes
        for (int i = 0; i < N_RANDOM; i++) begin
            logic [2:0] xc, yc, zc;
            xc = 3'($urandom_range(0, 5));
            yc = 3'($urandom_range(0, 5));
            zc = 3'($urandom_range(0, 5));
            apply(xc, yc, zc, mk(xc), mk(yc), mk(zc), 1'($urandom_range(0, 1)));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule